// File: doc/BRIEF.md
# Camera Interface Interrupt Controller

This block gathers event pulses from five camera stream interfaces and holds them as status. Two of the interfaces carry pixel streams and three carry raw streams. Each interface owns a fixed 13-bit group of event bits, and the groups are packed two to a 32-bit word across three words. A status bit is set only while its mask bit is set. One level interrupt line is high whenever a masked status bit is set.

Software handles the interrupt in two steps. It reads a status word and writes that value to the matching clear address. The write only stages the bits. A single global clear command then removes every staged bit in all three words at once. A mask command for one interface sets that interface's group to its standard enable pattern, or to zero, and leaves the neighbouring group untouched. The same command also stages the clearing of that interface's pattern bits.

A reset command starts a fixed countdown. When the countdown ends, a reset-done event is raised in status word 0.

Top module: `cif_irq_ctrl`

## Requirements
- R1: After reset, every mask word, every status word and every readable register reads 0, and `irq_o` is low.
- R2: A write to a mask address (0, 1 or 2) stores only the defined bits of that word: bits 25:0 and 27 of word 0, bits 25:0 of word 1, and bits 12:0 of word 2. A read of the same address returns the stored value.
- R3: Interface k (0 pix-0, 1 raw-0, 2 pix-1, 3 raw-1, 4 raw-2) drives `evt_i[13k+12:13k]`. Its bit j maps to status word k/2, bit 13*(k%2)+j. A pulse sets that bit on the next clock edge only if the mask bit is set; otherwise the status stays 0. Bit 12 of a group (word bit 12 or 25) is the overflow event.
- R4: A status bit stays set until it is cleared. `irq_o` is high exactly while some status word ANDed with its mask is non-zero, so it falls when the mask is removed, even though the status is still held.
- R5: A write to clear address 8, 9 or 10 (word 0, 1 or 2) only stages those bits and changes no status by itself. A write to address 12 with bit 0 = 1 removes all staged bits in one cycle and empties the staging. A write to address 12 with bit 0 = 0 does nothing.
- R6: If an event arrives in the same cycle as the global clear that removes its bit, the bit stays set.
- R7: A write to address 3 is an interface command. Bits 2:0 give the interface index and bit 3 the enable. The command sets the interface's group to the pattern 0x1249 (bits 0, 3, 6, 9 and 12 of the group) when the enable is 1, or to zero when it is 0. This gives 0x00001249 for a low group and 0x02492000 for a high group. The other group in the word is unchanged. The command also stages the pattern bits for clearing. An index above 4 is ignored.
- R8: A write to address 13 with bit 0 = 1 sets status word 0 bit 27 (reset done) exactly RST_DELAY clock edges after the write edge, provided mask word 0 bit 27 is set.
- R9: Status words read at addresses 4, 5 and 6. Clear, command and global-clear addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| evt_i | input | 65 | Event pulses, 13 bits per interface |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong mask or status bit shows at the ports in one of two ways: in the next status read, or through `irq_o` on the clock edge after the event that should have set it. A wrong staging register stays hidden until the next global clear, when a status bit is removed or left behind. The bench therefore reads status right after each global clear. A reset countdown that is off by one cycle shows as bit 27 of word 0 appearing one read early or one read late.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam int GROUP_W   = 13;
  localparam int NUM_IF    = 5;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int NUM_WORDS = (NUM_IF + 1) / 2;
  localparam int RST_BIT   = 2 * GROUP_W + 1;
  localparam int PAT_STEP  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK0  = 4'd0,
    A_IFCMD  = 4'd3,
    A_STAT0  = 4'd4,
    A_CLR0   = 4'd8,
    A_GCLR   = 4'd12,
    A_RSTCMD = 4'd13
  } cif_addr_e;

  // bits occupied by one interface group (half 0 = low, 1 = high)
  function automatic logic [WORD_W-1:0] group_bits(int half);
    logic [WORD_W-1:0] b;
    b = '0;
    for (int j = 0; j < GROUP_W; j++) b[half*GROUP_W+j] = 1'b1;
    return b;
  endfunction

  // standard enable pattern: every third bit of the group
  function automatic logic [WORD_W-1:0] enable_pat(int half);
    logic [WORD_W-1:0] p;
    p = '0;
    for (int j = 0; j < GROUP_W; j += PAT_STEP) p[half*GROUP_W+j] = 1'b1;
    return p;
  endfunction

  // defined bits of status/mask word w
  function automatic logic [WORD_W-1:0] valid_bits(int w);
    logic [WORD_W-1:0] v;
    v = '0;
    for (int k = 0; k < NUM_IF; k++)
      if (k / 2 == w) v = v | group_bits(k % 2);
    if (w == 0) v[RST_BIT] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/cif_stat_word.sv
module cif_stat_word #(
  parameter int          W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  input  logic [W-1:0] cfg_clr_i,
  input  logic         apply_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_n, pend_q, pend_n, hit;
  logic         stat_en, pend_en;

  assign hit = evt_i & mask_i & VALID;

  always_comb begin
    stat_en = apply_i | (|hit);
    stat_n  = (stat_q & ~(apply_i ? pend_q : '0)) | hit;
    pend_en = apply_i | clr_wr_i | (|cfg_clr_i);
    if (apply_i) pend_n = '0;
    else         pend_n = pend_q | (clr_wr_i ? (clr_data_i & VALID) : '0) | cfg_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= '0;
    end else begin
      if (stat_en) stat_q <= stat_n;
      if (pend_en) pend_q <= pend_n;
    end
  end

  assign stat_o = stat_q;

  AST_HOLD_WITHOUT_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |=> (($past(stat_q) & ~stat_q) == '0)); // R5
  AST_PEND_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i |=> (pend_q == '0)); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((stat_q & $past(hit)) == $past(hit))); // R6
  AST_NO_UNMASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i & mask_i)) == '0)); // R3
endmodule

// File: rtl/cif_rst_timer.sv
module cif_rst_timer #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i | (cnt_q != '0);
    if (start_i) cnt_n = CW'(DELAY);
    else         cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign done_o = (cnt_q == CW'(1));

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o); // R8
endmodule

// File: rtl/cif_irq_ctrl.sv
module cif_irq_ctrl
  import cif_pkg::*;
#(
  parameter int RST_DELAY = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IF*GROUP_W-1:0] evt_i,
  input  logic                      bus_wr_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [WORD_W-1:0]         bus_wdata_i,
  output logic [WORD_W-1:0]         bus_rdata_o,
  output logic                      irq_o
);
  logic [WORD_W-1:0]    mask_q  [NUM_WORDS];
  logic [WORD_W-1:0]    mask_n  [NUM_WORDS];
  logic [WORD_W-1:0]    stat    [NUM_WORDS];
  logic [WORD_W-1:0]    evw     [NUM_WORDS];
  logic [WORD_W-1:0]    cfg_clr [NUM_WORDS];
  logic [NUM_WORDS-1:0] clr_wr, mask_en;
  logic                 apply, rst_start, rst_done, cmd_hit, cmd_en;
  logic [2:0]           cmd_idx;

  assign cmd_idx   = bus_wdata_i[2:0];
  assign cmd_en    = bus_wdata_i[3];
  assign cmd_hit   = bus_wr_i && (bus_addr_i == A_IFCMD) && (int'(cmd_idx) < NUM_IF);
  assign apply     = bus_wr_i && (bus_addr_i == A_GCLR) && bus_wdata_i[0];
  assign rst_start = bus_wr_i && (bus_addr_i == A_RSTCMD) && bus_wdata_i[0];

  // mask next state: full-word write or per-interface command
  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      mask_n[w]  = mask_q[w];
      cfg_clr[w] = '0;
      mask_en[w] = 1'b0;
      clr_wr[w]  = bus_wr_i && (bus_addr_i == ADDR_W'(int'(A_CLR0) + w));
      if (bus_wr_i && (bus_addr_i == ADDR_W'(int'(A_MASK0) + w))) begin
        mask_n[w]  = bus_wdata_i & valid_bits(w);
        mask_en[w] = 1'b1;
      end
      if (cmd_hit && (int'(cmd_idx[2:1]) == w)) begin
        mask_n[w]  = (mask_q[w] & ~group_bits(int'(cmd_idx[0])))
                   | (cmd_en ? enable_pat(int'(cmd_idx[0])) : '0);
        cfg_clr[w] = enable_pat(int'(cmd_idx[0]));
        mask_en[w] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) mask_q[w] <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (mask_en[w]) mask_q[w] <= mask_n[w];
    end
  end

  // event routing into word positions
  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) evw[w] = '0;
    for (int k = 0; k < NUM_IF; k++)
      evw[k/2][(k%2)*GROUP_W +: GROUP_W] = evt_i[k*GROUP_W +: GROUP_W];
    evw[0][RST_BIT] = rst_done;
  end

  cif_rst_timer #(.DELAY(RST_DELAY)) u_rst_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rst_start),
    .done_o  (rst_done)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    cif_stat_word #(.W(WORD_W), .VALID(valid_bits(w))) u_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evw[w]),
      .mask_i     (mask_q[w]),
      .clr_wr_i   (clr_wr[w]),
      .clr_data_i (bus_wdata_i),
      .cfg_clr_i  (cfg_clr[w]),
      .apply_i    (apply),
      .stat_o     (stat[w])
    );
  end

  always_comb begin
    irq_o       = 1'b0;
    bus_rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      irq_o = irq_o | (|(stat[w] & mask_q[w]));
      if (bus_addr_i == ADDR_W'(int'(A_MASK0) + w)) bus_rdata_o = mask_q[w];
      if (bus_addr_i == ADDR_W'(int'(A_STAT0) + w)) bus_rdata_o = stat[w];
    end
  end

  AST_CMD_KEEPS_NEIGHBOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !cmd_idx[0]) |=> (($past(mask_q[int'(cmd_idx[2:1])]) & group_bits(1))
                                  == (mask_q[$past(int'(cmd_idx[2:1]))] & group_bits(1)))); // R7
endmodule

// File: tb/tb_cif_irq_ctrl.sv
module tb_cif_irq_ctrl;
  localparam int D  = 16;
  localparam int EW = 65;

  logic        clk, rst_n, bus_wr, irq;
  logic [EW-1:0] evt;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int errors = 0, checks = 0;
  logic [31:0] m_mask [3];
  logic [31:0] m_stat [3];
  logic [31:0] m_pend [3];
  int m_cnt;

  cif_irq_ctrl #(.RST_DELAY(D)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] vbits(int w);
    if (w == 0) return 32'h0BFF_FFFF;
    if (w == 1) return 32'h03FF_FFFF;
    return 32'h0000_1FFF;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_update();
    logic [31:0] ev [3];
    logic apply, rdone;
    int w, h;
    rdone = (m_cnt == 1);
    for (int i = 0; i < 3; i++) ev[i] = 32'h0;
    for (int k = 0; k < 5; k++)
      ev[k/2] = ev[k/2] | (32'((evt >> (13*k)) & 65'h1FFF) << (13*(k%2)));
    if (rdone) ev[0][27] = 1'b1;
    apply = bus_wr && bus_addr == 4'd12 && bus_wdata[0];
    for (int i = 0; i < 3; i++)
      m_stat[i] = (m_stat[i] & ~(apply ? m_pend[i] : 32'h0)) | (ev[i] & m_mask[i]);
    for (int i = 0; i < 3; i++) begin
      if (apply) m_pend[i] = 32'h0;
      else if (bus_wr && bus_addr == 4'(8+i)) m_pend[i] = m_pend[i] | (bus_wdata & vbits(i));
      if (bus_wr && bus_addr == 4'(i)) m_mask[i] = bus_wdata & vbits(i);
    end
    if (bus_wr && bus_addr == 4'd3 && bus_wdata[2:0] < 3'd5) begin
      w = int'(bus_wdata[2:1]);
      h = int'(bus_wdata[0]);
      m_mask[w] = (m_mask[w] & ~(32'h1FFF << (13*h))) | (bus_wdata[3] ? (32'h1249 << (13*h)) : 32'h0);
      m_pend[w] = m_pend[w] | (32'h1249 << (13*h));
    end
    if (bus_wr && bus_addr == 4'd13 && bus_wdata[0]) m_cnt = D;
    else if (m_cnt > 0) m_cnt--;
  endtask

  // one clock: model follows the edge, irq compared every cycle (R4)
  task automatic step();
    logic e;
    @(posedge clk);
    model_update();
    @(negedge clk);
    e = 1'b0;
    for (int i = 0; i < 3; i++) e = e | (|(m_stat[i] & m_mask[i]));
    chk("R4 irq", {31'h0, irq}, {31'h0, e});
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic pulse(int k, logic [12:0] bits);
    evt = EW'(bits) << (13*k);
    step();
    evt = '0;
  endtask

  function automatic logic [31:0] model_read(logic [3:0] a);
    if (a <= 4'd2) return m_mask[a];
    if (a >= 4'd4 && a <= 4'd6) return m_stat[a-4];
    return 32'h0;
  endfunction

  task automatic rd(string req, logic [3:0] a);
    bus_addr = a; #1;
    chk(req, bus_rdata, model_read(a));
  endtask

  task automatic rd_lit(string req, logic [3:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'h0; evt = '0;
    for (int i = 0; i < 3; i++) begin m_mask[i] = 0; m_stat[i] = 0; m_pend[i] = 0; end
    m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 14; a++) rd_lit("R1 reset read", 4'(a), 32'h0);
    chk("R1 irq low", {31'h0, irq}, 32'h0);

    // R2 defined bits only
    wr(4'd0, 32'hFFFF_FFFF); rd_lit("R2 mask0", 4'd0, 32'h0BFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF); rd_lit("R2 mask1", 4'd1, 32'h03FF_FFFF);
    wr(4'd2, 32'hFFFF_FFFF); rd_lit("R2 mask2", 4'd2, 32'h0000_1FFF);
    for (int w = 0; w < 3; w++) wr(4'(w), 32'h0);

    // R3 unmasked events ignored
    for (int k = 0; k < 5; k++) pulse(k, 13'h1FFF);
    for (int w = 0; w < 3; w++) rd_lit("R3 unmasked", 4'(4+w), 32'h0);

    // R7 interface command
    wr(4'd3, 32'h8);  rd_lit("R7 pix0 enable", 4'd0, 32'h0000_1249);
    wr(4'd3, 32'h9);  rd_lit("R7 raw0 enable", 4'd0, 32'h0249_3249);
    wr(4'd3, 32'hD);  rd_lit("R7 bad index", 4'd0, 32'h0249_3249);
    rd_lit("R7 bad index w2", 4'd2, 32'h0);
    wr(4'd12, 32'h1); // flush pattern clears staged by the commands

    // R3 masked latch and overflow position, R4 irq
    pulse(0, 13'h1FFF); rd_lit("R3 pix0 latch", 4'd4, 32'h0000_1249);
    chk("R4 irq high", {31'h0, irq}, 32'h1);
    pulse(1, 13'h1000); rd_lit("R3 raw0 overflow", 4'd4, 32'h0200_1249);

    // R5 two-phase clear
    wr(4'd8, 32'h0000_1249); rd_lit("R5 staged only", 4'd4, 32'h0200_1249);
    wr(4'd12, 32'h0);        rd_lit("R5 gclr bit0 zero", 4'd4, 32'h0200_1249);
    wr(4'd12, 32'h1);        rd_lit("R5 applied", 4'd4, 32'h0200_0000);
    wr(4'd12, 32'h1);        rd_lit("R5 staging emptied", 4'd4, 32'h0200_0000);

    // R6 event beats clear in the same cycle
    wr(4'd8, 32'h0200_0000);
    evt = EW'(13'h1000) << 13;
    wr(4'd12, 32'h1);
    evt = '0;
    rd_lit("R6 event wins", 4'd4, 32'h0200_0000);
    wr(4'd8, 32'h0200_0000); wr(4'd12, 32'h1);
    rd_lit("R6 later clear", 4'd4, 32'h0);

    // R7 disable keeps neighbour, command stages pattern clear
    wr(4'd3, 32'h0); rd_lit("R7 pix0 disable", 4'd0, 32'h0249_2000);
    wr(4'd3, 32'h8); pulse(0, 13'h1249);
    rd_lit("R7 set before gclr", 4'd4, 32'h0000_1249);
    wr(4'd12, 32'h1); rd_lit("R7 command clear applied", 4'd4, 32'h0);

    // other interfaces: pix1, raw1, raw2
    wr(4'd3, 32'hA); wr(4'd3, 32'hB); wr(4'd3, 32'hC); wr(4'd12, 32'h1);
    rd_lit("R7 word1", 4'd1, 32'h0249_3249);
    rd_lit("R7 word2", 4'd2, 32'h0000_1249);
    pulse(4, 13'h1001); rd_lit("R3 raw2", 4'd6, 32'h0000_1001);
    pulse(3, 13'h0008); rd_lit("R3 raw1", 4'd5, 32'h0001_0000);
    rd("R9 stat1 model", 4'd5);
    for (int a = 8; a < 14; a++) rd_lit("R9 write-only reads", 4'(a), 32'h0);

    // R4 irq falls when mask removed, status held
    wr(4'd2, 32'h0); wr(4'd1, 32'h0);
    rd_lit("R4 status held", 4'd6, 32'h0000_1001);
    chk("R4 irq after unmask", {31'h0, irq}, 32'h0);

    // R8 reset-done timing
    wr(4'd0, 32'h0800_0000);
    wr(4'd13, 32'h1);
    repeat (D-1) step();
    rd_lit("R8 not yet", 4'd4, 32'h0);
    step();
    rd_lit("R8 done", 4'd4, 32'h0800_0000);
    chk("R8 irq", {31'h0, irq}, 32'h1);
    repeat (4) step();
    rd("R8 stays", 4'd4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule